// File: doc/BRIEF.md
# Write Protection Command Sequencer

This block sits beside the page-load controller of a byte-wide non-volatile memory. It watches every byte write on the internal bus and looks for two fixed address/data command sequences. A three-write key arms write protection. A six-write key clears it. It keeps the protect flag and gives each write a combinational "commit allowed" qualifier. The page controller uses that qualifier to decide whether the byte goes into the page buffer.

The three-write key also acts as an unlock prefix. Once it has been seen, data bytes that follow in the same load window are committed even when protection is already on, and protection is armed, or stays armed, when that window closes. Any change to the protect flag takes effect only on the load-window timeout pulse, which marks the start of the internal write cycle. A timeout that arrives part way through a sequence discards it. The flag is non-volatile, so it is modelled as a register that loads a preset input while reset is held.

Top module: `wps_top`

## Requirements
- R1: While `rstN` is low, `protect` follows `protPreset`. After reset the sequencer is idle.
- R2: When `protect` is 0, an ordinary write (one that is not a command step) has `commitOk` = 1 in the cycle its strobe is high.
- R3: When `protect` is 1 and no unlock is active, an ordinary write has `commitOk` = 0 and leaves `protect` unchanged.
- R4: Key A is the three writes AAh to address 5555h, then 55h to 2AAAh, then A0h to 5555h. Each key write has `commitOk` = 0. Later data writes in the same window have `commitOk` = 1. `protect` goes to 1 on the clock edge where `loadTimeout` is high, and not before.
- R5: Key B is the six writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h. Each key write has `commitOk` = 0. `protect` stays 1 for the rest of the window, including for data writes, and goes to 0 on the `loadTimeout` edge.
- R6: A write that does not match the expected next step of a sequence returns the sequencer to idle. That write gets the ordinary `commitOk` of R2 or R3.
- R7: `loadTimeout` during a partial sequence returns the sequencer to idle and leaves `protect` unchanged. The rest of the sequence after the timeout is treated as ordinary writes.
- R8: The unlock given by key A ends on the `loadTimeout` edge. A write after that edge is dropped while `protect` is 1.
- R9: `commitOk` is 0 in any cycle where `wrStrobe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| protPreset | input | 1 | Stored protect value loaded during reset |
| wrStrobe | input | 1 | One-cycle byte write strobe |
| wrAddr | input | 15 | Write address |
| wrData | input | 8 | Write data |
| loadTimeout | input | 1 | Pulse: page-load window closed, write cycle starts |
| protect | output | 1 | Current write-protect state |
| commitOk | output | 1 | The current write may be stored in the array |

## Verification
The assertions assume that `loadTimeout` is a single-cycle pulse that never falls in the same cycle as `wrStrobe`, and that address and data are stable whenever the strobe is high. The bench drives each write for exactly one cycle and raises the timeout only in a separate cycle. This keeps every scenario inside those assumptions. The timeout is placed deliberately before a sequence, part way through one, and after one has completed, so that every window boundary the design can see is covered.

// File: rtl/wps_pkg.sv
package wps_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_K1,
    SEQ_K2,
    SEQ_B3,
    SEQ_B4,
    SEQ_B5
  } seqState_t;

  typedef struct packed {
    logic cmdStep;   // current write is consumed as a sequence step
    logic enDone;    // arming key completed on this write
    logic disDone;   // clearing key completed on this write
  } ctlStrb_t;

endpackage

// File: rtl/wps_control.sv
module wps_control
  import wps_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_P = 15'h5555,
  parameter logic [ADDR_W-1:0] ADDR_Q = 15'h2AAA,
  parameter logic [DATA_W-1:0] KEY_1  = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_2  = 8'h55,
  parameter logic [DATA_W-1:0] KEY_EN = 8'hA0,
  parameter logic [DATA_W-1:0] KEY_X  = 8'h80,
  parameter logic [DATA_W-1:0] KEY_DS = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              loadTimeout,
  output ctlStrb_t          strb
);

  seqState_t state, stateNxt;

  logic atP, atQ;
  assign atP = (wrAddr == ADDR_P);
  assign atQ = (wrAddr == ADDR_Q);

  logic hitK1, hitK2, hitEn, hitX, hitDs;
  assign hitK1 = atP && (wrData == KEY_1);
  assign hitK2 = atQ && (wrData == KEY_2);
  assign hitEn = atP && (wrData == KEY_EN);
  assign hitX  = atP && (wrData == KEY_X);
  assign hitDs = atP && (wrData == KEY_DS);

  always_comb begin
    stateNxt = SEQ_IDLE;
    strb     = '0;
    if (wrStrobe) begin
      unique case (state)
        SEQ_IDLE: if (hitK1) begin stateNxt = SEQ_K1; strb.cmdStep = 1'b1; end
        SEQ_K1:   if (hitK2) begin stateNxt = SEQ_K2; strb.cmdStep = 1'b1; end
        SEQ_K2: begin
          if (hitEn) begin
            strb.cmdStep = 1'b1;
            strb.enDone  = 1'b1;
          end else if (hitX) begin
            stateNxt     = SEQ_B3;
            strb.cmdStep = 1'b1;
          end
        end
        SEQ_B3:   if (hitK1) begin stateNxt = SEQ_B4; strb.cmdStep = 1'b1; end
        SEQ_B4:   if (hitK2) begin stateNxt = SEQ_B5; strb.cmdStep = 1'b1; end
        SEQ_B5: begin
          if (hitDs) begin
            strb.cmdStep = 1'b1;
            strb.disDone = 1'b1;
          end
        end
        default: stateNxt = SEQ_IDLE;
      endcase
    end else begin
      stateNxt = state;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            state <= SEQ_IDLE;
    else if (loadTimeout) state <= SEQ_IDLE;
    else                  state <= stateNxt;
  end

  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    loadTimeout |=> state == SEQ_IDLE); // R7

  AST_MISMATCH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !loadTimeout && state != SEQ_IDLE && !strb.cmdStep) |=> state == SEQ_IDLE); // R6

  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.enDone && strb.disDone)); // R5

endmodule

// File: rtl/wps_datapath.sv
module wps_datapath
  import wps_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     protPreset,
  input  logic     wrStrobe,
  input  logic     loadTimeout,
  input  ctlStrb_t strb,
  output logic     protect,
  output logic     commitOk
);

  logic pendSet, pendClr, unlocked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protect  <= protPreset;
      pendSet  <= 1'b0;
      pendClr  <= 1'b0;
      unlocked <= 1'b0;
    end else if (loadTimeout) begin
      if (pendSet)      protect <= 1'b1;
      else if (pendClr) protect <= 1'b0;
      pendSet  <= 1'b0;
      pendClr  <= 1'b0;
      unlocked <= 1'b0;
    end else if (strb.enDone) begin
      pendSet  <= 1'b1;
      pendClr  <= 1'b0;
      unlocked <= 1'b1;
    end else if (strb.disDone) begin
      pendSet  <= 1'b0;
      pendClr  <= 1'b1;
    end
  end

  assign commitOk = wrStrobe && !strb.cmdStep && (!protect || unlocked);

  AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !loadTimeout |=> $stable(protect)); // R4

  AST_CLEAR_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rstN)
    (protect && !pendClr) |=> protect); // R5

  AST_UNLOCK_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    loadTimeout |=> !unlocked); // R8

endmodule

// File: rtl/wps_top.sv
module wps_top
  import wps_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              protPreset,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              loadTimeout,
  output logic              protect,
  output logic              commitOk
);

  ctlStrb_t ctl;

  wps_control #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtl (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrAddr(wrAddr),
    .wrData(wrData), .loadTimeout(loadTimeout), .strb(ctl)
  );

  wps_datapath uDp (
    .clk(clk), .rstN(rstN), .protPreset(protPreset), .wrStrobe(wrStrobe),
    .loadTimeout(loadTimeout), .strb(ctl), .protect(protect), .commitOk(commitOk)
  );

  AST_CMD_NEVER_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cmdStep |-> !commitOk); // R4

  AST_QUIET_NO_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |-> !commitOk); // R9

endmodule

// File: tb/tb_wps_top.sv
module tb_wps_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        protPreset = 1'b0;
  logic        wrStrobe = 1'b0;
  logic [14:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        loadTimeout = 1'b0;
  logic        protect, commitOk;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  wps_top dut (
    .clk(clk), .rstN(rstN), .protPreset(protPreset), .wrStrobe(wrStrobe),
    .wrAddr(wrAddr), .wrData(wrData), .loadTimeout(loadTimeout),
    .protect(protect), .commitOk(commitOk)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset(input logic preset);
    @(negedge clk);
    rstN = 1'b0;
    protPreset = preset;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #2 chk("R1 protect after reset", protect, preset);
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d,
                    input logic expCommit, input string req);
    @(negedge clk);
    wrStrobe = 1'b1; wrAddr = a; wrData = d;
    #2 chk(req, commitOk, expCommit);
    @(posedge clk);
    #1 wrStrobe = 1'b0;
  endtask

  task automatic timeoutPulse;
    @(negedge clk);
    loadTimeout = 1'b1;
    @(posedge clk);
    #1 loadTimeout = 1'b0;
  endtask

  task automatic tReset;
    doReset(1'b0);
    wr(15'h0100, 8'h11, 1'b1, "R2 unprotected write");
    @(negedge clk); #2 chk("R9 no strobe no commit", commitOk, 1'b0);
    doReset(1'b1);
    wr(15'h0100, 8'h22, 1'b0, "R3 protected write dropped");
    #2 chk("R3 protect unchanged", protect, 1'b1);
  endtask

  task automatic tEnable;
    doReset(1'b0);
    wr(15'h5555, 8'hAA, 1'b0, "R4 key step 1");
    wr(15'h2AAA, 8'h55, 1'b0, "R4 key step 2");
    wr(15'h5555, 8'hA0, 1'b0, "R4 key step 3");
    chk("R4 protect waits for window", protect, 1'b0);
    wr(15'h0200, 8'h33, 1'b1, "R4 data after key");
    timeoutPulse();
    #2 chk("R4 protect set at timeout", protect, 1'b1);
    wr(15'h0200, 8'h34, 1'b0, "R8 write after window dropped");
  endtask

  task automatic tUnlockWhileProtected;
    doReset(1'b1);
    wr(15'h5555, 8'hAA, 1'b0, "R4 locked key step 1");
    wr(15'h2AAA, 8'h55, 1'b0, "R4 locked key step 2");
    wr(15'h5555, 8'hA0, 1'b0, "R4 locked key step 3");
    wr(15'h1234, 8'h5A, 1'b1, "R4 unlocked data 1");
    wr(15'h1235, 8'h5B, 1'b1, "R4 unlocked data 2");
    timeoutPulse();
    #2 chk("R4 protect kept", protect, 1'b1);
    wr(15'h1236, 8'h5C, 1'b0, "R8 unlock closed");
  endtask

  task automatic tDisable;
    doReset(1'b1);
    wr(15'h5555, 8'hAA, 1'b0, "R5 step 1");
    wr(15'h2AAA, 8'h55, 1'b0, "R5 step 2");
    wr(15'h5555, 8'h80, 1'b0, "R5 step 3");
    wr(15'h5555, 8'hAA, 1'b0, "R5 step 4");
    wr(15'h2AAA, 8'h55, 1'b0, "R5 step 5");
    wr(15'h5555, 8'h20, 1'b0, "R5 step 6");
    chk("R5 protect held in window", protect, 1'b1);
    wr(15'h0400, 8'h44, 1'b0, "R5 data in same window dropped");
    timeoutPulse();
    #2 chk("R5 protect cleared at timeout", protect, 1'b0);
    wr(15'h0400, 8'h45, 1'b1, "R5 write after clear");
  endtask

  task automatic tMismatch;
    doReset(1'b0);
    wr(15'h5555, 8'hAA, 1'b0, "R6 prefix");
    wr(15'h1234, 8'h55, 1'b1, "R6 wrong address is ordinary");
    wr(15'h2AAA, 8'h55, 1'b1, "R6 back to idle");
    timeoutPulse();
    doReset(1'b1);
    wr(15'h5555, 8'hAA, 1'b0, "R6 prefix locked");
    wr(15'h2AAA, 8'h77, 1'b0, "R6 wrong data dropped when locked");
    wr(15'h5555, 8'hA0, 1'b0, "R6 orphan tail dropped");
    wr(15'h0500, 8'h01, 1'b0, "R6 no unlock granted");
    timeoutPulse();
    #2 chk("R6 protect unchanged", protect, 1'b1);
  endtask

  task automatic tAbort;
    doReset(1'b1);
    wr(15'h5555, 8'hAA, 1'b0, "R7 step 1");
    wr(15'h2AAA, 8'h55, 1'b0, "R7 step 2");
    wr(15'h5555, 8'h80, 1'b0, "R7 step 3");
    wr(15'h5555, 8'hAA, 1'b0, "R7 step 4");
    timeoutPulse();
    #2 chk("R7 protect after abort", protect, 1'b1);
    wr(15'h2AAA, 8'h55, 1'b0, "R7 tail step 5 ordinary");
    wr(15'h5555, 8'h20, 1'b0, "R7 tail step 6 ordinary");
    timeoutPulse();
    #2 chk("R7 protect still set", protect, 1'b1);
    doReset(1'b0);
    wr(15'h5555, 8'hAA, 1'b0, "R7 enable step 1");
    wr(15'h2AAA, 8'h55, 1'b0, "R7 enable step 2");
    timeoutPulse();
    wr(15'h5555, 8'hA0, 1'b1, "R7 enable tail ordinary");
    timeoutPulse();
    #2 chk("R7 protect not armed", protect, 1'b0);
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    tReset();
    tEnable();
    tUnlockWhileProtected();
    tDisable();
    tMismatch();
    tAbort();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule